// File: doc/BRIEF.md
# Dual-Bank Data Cache Tag Lookup with Selectable Bank Bit

This block is the tag-lookup front end of a 32 KB data cache whose storage is split into two 16 KB banks, A and B. Each bank is 2-way set-associative with 256 sets of 32-byte lines. A single mode input decides which of two address bits, bit 14 or bit 23, steers an access to bank A or bank B. The bit that is not used for steering becomes part of the stored tag, so it still takes part in the hit/miss decision.

A lookup is presented as a request strobe with a 32-bit address. One clock later the block reports the bank, the set index, a hit flag and the way that hit. A separate fill strobe with its own address installs a tag after a miss. The fill writes the least recently used way of the indexed set in the selected bank. Any change of the mode input clears every entry in both banks, because each stored tag was built under the old mapping. The data arrays, line transfers, write-back and coherence sit outside this block.

Top module: `cbsel_lookup`

## Requirements
- R1: After a synchronous active-low reset, `resp_valid` and `resp_hit` are 0 and every entry in both banks is invalid, so any lookup misses.
- R2: With `cfg_sel` = 0, address bit 14 picks the bank and is reported on `resp_bank` (0 = bank A, 1 = bank B), so successive 16 KB pages alternate between the banks.
- R3: With `cfg_sel` = 1, address bit 23 picks the bank in the same way (0 = bank A, 1 = bank B).
- R4: A request in cycle t gives `resp_valid` = 1 in cycle t+1 only, with `resp_set` equal to address bits 12:5 of that request.
- R5: The stored tag is address bits 31:13 with the bank-select bit removed. With `cfg_sel` = 0, addresses that differ only in bit 23 do not hit each other. With `cfg_sel` = 1, the same holds for bit 14.
- R6: `resp_hit` is 1 only when a valid entry of the indexed set in the selected bank holds the address tag. `resp_way` (0 or 1) then names the way holding it. `resp_hit` is never 1 when `resp_valid` is 0.
- R7: A fill writes the tag into the least recently used way of the indexed set in the selected bank and marks it valid. In a set that is still empty, the first fill goes to way 0 and the second to way 1.
- R8: Every hit and every fill marks the way it used as most recently used. Of two addresses sharing a set, the one not touched last is the one the next fill evicts.
- R9: A change of `cfg_sel` clears every entry in both banks. A lookup in the cycle of the change reports a miss, a fill in that cycle is dropped, and tags installed before the change never hit afterwards.
- R10: When a fill and a lookup arrive in the same cycle, the lookup sees the contents from before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sel | input | 1 | Bank-select mode: 0 = bit 14 steers, 1 = bit 23 steers |
| req | input | 1 | Lookup strobe |
| addr | input | 32 | Lookup byte address |
| fill | input | 1 | Tag fill strobe |
| fill_addr | input | 32 | Byte address whose tag is installed |
| resp_valid | output | 1 | Lookup result valid, one cycle after `req` |
| resp_bank | output | 1 | Selected bank: 0 = A, 1 = B |
| resp_set | output | 8 | Set index, address bits 12:5 |
| resp_hit | output | 1 | Lookup hit |
| resp_way | output | 1 | Way that hit |

## Verification
On every cycle the assertions check the one-cycle response timing, the bank bit under each mode, the set field, that no hit is reported without a response, and that a lookup in a mode-change cycle misses. Only the directed scenarios can show the behaviour that depends on stored contents: tags that differ only in the non-steering bit, LRU victim choice after a mix of hits and fills, the loss of all entries across a mode change, and a lookup that sees the state from before a fill in the same cycle.

// File: rtl/cbsel_pkg.sv
// Package cbsel_pkg
// Shared geometry, types and the tag-forming helper for the bank-select
// cache lookup. Assumes two ways per set (a single LRU bit per set).
package cbsel_pkg;
    parameter int ADDR_W     = 32;
    parameter int LINE_OFF_W = 5;
    parameter int SET_W      = 8;
    parameter int WAYS       = 2;
    parameter int TAG_LSB    = LINE_OFF_W + SET_W;
    parameter int FIELD_W    = ADDR_W - TAG_LSB;
    parameter int TAG_W      = FIELD_W - 1;
    parameter int SETS       = 1 << SET_W;

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [SET_W-1:0] set_t;

    // Remove bit 'pos' from the upper address field to form a compact tag.
    function automatic tag_t strip_bit(input logic [FIELD_W-1:0] f, input int pos);
        tag_t t;
        for (int i = 0; i < TAG_W; i++) begin
            t[i] = (i < pos) ? f[i] : f[i+1];
        end
        return t;
    endfunction
endpackage

// File: rtl/cbsel_addr_split.sv
// Module cbsel_addr_split
// Splits a line address into bank, set index and tag for the active mode.
// Assumes both candidate bank bits lie inside the tag field (>= TAG_LSB).
module cbsel_addr_split
    import cbsel_pkg::*;
#(
    parameter int SEL_LO = 14,
    parameter int SEL_HI = 23
) (
    input  logic [ADDR_W-1:LINE_OFF_W] line_addr,
    input  logic                       mode,
    output logic                       bank,
    output set_t                       set_idx,
    output tag_t                       tag
);
    localparam int POS_LO = SEL_LO - TAG_LSB;
    localparam int POS_HI = SEL_HI - TAG_LSB;

    // Pick the steering bit, slice the index and fold the other bit into the tag.
    always_comb begin
        bank    = mode ? line_addr[SEL_HI] : line_addr[SEL_LO];
        set_idx = line_addr[TAG_LSB-1:LINE_OFF_W];
        tag     = strip_bit(line_addr[ADDR_W-1:TAG_LSB], mode ? POS_HI : POS_LO);
    end
endmodule

// File: rtl/cbsel_tag_bank.sv
// Module cbsel_tag_bank
// One 2-way tag bank: tag store, per-way valid bits and one LRU bit per set.
// Lookup is combinational on the current contents. A fill replaces the LRU
// way; when a fill and a hit touch the same set, the fill's LRU update wins.
// Assumes the caller never fills a tag that is already present.
module cbsel_tag_bank
    import cbsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic look_en,
    input  set_t look_set,
    input  tag_t look_tag,
    input  logic fill_en,
    input  set_t fill_set,
    input  tag_t fill_tag,
    output logic look_hit,
    output logic look_way
);
    tag_t            tag_q [SETS][WAYS];
    logic [WAYS-1:0] vld_q [SETS];
    logic            lru_q [SETS];
    logic [WAYS-1:0] way_hit;
    logic            victim;

    // Per-way tag compare for the looked-up set.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = vld_q[look_set][w] && (tag_q[look_set][w] == look_tag);
    end

    // Reduce the way compares to a hit flag and way number.
    always_comb begin
        look_hit = |way_hit;
        look_way = way_hit[1];
        victim   = lru_q[fill_set];
    end

    // Tag storage write on fill (no reset needed, guarded by valid bits).
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_set][victim] <= fill_tag;
        end
    end

    // Valid and LRU state: cleared on reset or flush, updated on hit and fill.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                lru_q[s] <= 1'b0;
            end
        end else begin
            if (look_en && look_hit) begin
                lru_q[look_set] <= ~look_way;
            end
            if (fill_en) begin
                vld_q[fill_set][victim] <= 1'b1;
                lru_q[fill_set]         <= ~victim;
            end
        end
    end
endmodule

// File: rtl/cbsel_lookup.sv
// Module cbsel_lookup (top)
// Tag-lookup front end for a two-bank data cache. cfg_sel chooses which
// address bit steers between the banks; the other one stays in the tag.
// Lookup results are registered and appear one cycle after req. A change of
// cfg_sel flushes both banks; in that cycle lookups miss and fills drop.
module cbsel_lookup
    import cbsel_pkg::*;
#(
    parameter int SEL_LO = 14,
    parameter int SEL_HI = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sel,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              fill,
    input  logic [ADDR_W-1:0] fill_addr,
    output logic              resp_valid,
    output logic              resp_bank,
    output logic [SET_W-1:0]  resp_set,
    output logic              resp_hit,
    output logic              resp_way
);
    localparam int BANKS = 2;

    logic             cfg_q;
    logic             flush;
    logic             lk_bank, fl_bank;
    set_t             lk_set, fl_set;
    tag_t             lk_tag, fl_tag;
    logic [BANKS-1:0] bank_hit, bank_way;
    logic             unused_line_off;

    assign unused_line_off = ^{addr[LINE_OFF_W-1:0], fill_addr[LINE_OFF_W-1:0]};
    assign flush           = (cfg_sel != cfg_q);

    // Remember the mode the stored tags were built under.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= 1'b0;
        else        cfg_q <= cfg_sel;
    end

    cbsel_addr_split #(.SEL_LO(SEL_LO), .SEL_HI(SEL_HI)) u_split_look (
        .line_addr (addr[ADDR_W-1:LINE_OFF_W]),
        .mode      (cfg_sel),
        .bank      (lk_bank),
        .set_idx   (lk_set),
        .tag       (lk_tag)
    );

    cbsel_addr_split #(.SEL_LO(SEL_LO), .SEL_HI(SEL_HI)) u_split_fill (
        .line_addr (fill_addr[ADDR_W-1:LINE_OFF_W]),
        .mode      (cfg_sel),
        .bank      (fl_bank),
        .set_idx   (fl_set),
        .tag       (fl_tag)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        cbsel_tag_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .look_en  (req && !flush && (lk_bank == b[0])),
            .look_set (lk_set),
            .look_tag (lk_tag),
            .fill_en  (fill && !flush && (fl_bank == b[0])),
            .fill_set (fl_set),
            .fill_tag (fl_tag),
            .look_hit (bank_hit[b]),
            .look_way (bank_way[b])
        );
    end

    // Register the selected bank's result one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_bank  <= 1'b0;
            resp_set   <= '0;
            resp_hit   <= 1'b0;
            resp_way   <= 1'b0;
        end else begin
            resp_valid <= req;
            resp_bank  <= lk_bank;
            resp_set   <= lk_set;
            resp_hit   <= req && !flush && bank_hit[lk_bank];
            resp_way   <= bank_way[lk_bank];
        end
    end
endmodule

// File: rtl/cbsel_lookup_chk.sv
// Module cbsel_lookup_chk
// Cycle-by-cycle protocol checks for cbsel_lookup, attached by bind.
module cbsel_lookup_chk #(
    parameter int SEL_LO = 14,
    parameter int SEL_HI = 23
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_sel,
    input logic        cfg_q,
    input logic        req,
    input logic [31:0] addr,
    input logic        resp_valid,
    input logic        resp_bank,
    input logic [7:0]  resp_set,
    input logic        resp_hit
);
    AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> resp_valid); // R4
    AST_NO_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !resp_valid); // R4
    AST_SET_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (resp_set == $past(addr[12:5]))); // R4
    AST_BANK_LOW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !cfg_sel) |=> (resp_bank == $past(addr[SEL_LO]))); // R2
    AST_BANK_HIGH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req && cfg_sel) |=> (resp_bank == $past(addr[SEL_HI]))); // R3
    AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (cfg_sel != cfg_q)) |=> !resp_hit); // R9
    AST_HIT_NEEDS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> !resp_hit); // R6
endmodule

bind cbsel_lookup cbsel_lookup_chk #(.SEL_LO(SEL_LO), .SEL_HI(SEL_HI)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_sel    (cfg_sel),
    .cfg_q      (cfg_q),
    .req        (req),
    .addr       (addr),
    .resp_valid (resp_valid),
    .resp_bank  (resp_bank),
    .resp_set   (resp_set),
    .resp_hit   (resp_hit)
);

// File: tb/cbsel_lookup_tb.sv
`timescale 1ns/1ps
module cbsel_lookup_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sel = 1'b0;
    logic        req = 1'b0;
    logic [31:0] addr = '0;
    logic        fill = 1'b0;
    logic [31:0] fill_addr = '0;
    logic        resp_valid, resp_bank, resp_hit, resp_way;
    logic [7:0]  resp_set;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    cbsel_lookup u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .req(req), .addr(addr),
        .fill(fill), .fill_addr(fill_addr), .resp_valid(resp_valid),
        .resp_bank(resp_bank), .resp_set(resp_set), .resp_hit(resp_hit),
        .resp_way(resp_way)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // One lookup; checks bank, set, valid, hit and (on hit) way.
    task automatic look(input logic [31:0] a, input string rq, input bit exp_hit, input bit exp_way);
        @(negedge clk);
        req = 1'b1; addr = a;
        @(negedge clk);
        req = 1'b0;
        chk("R4 resp_valid", {31'd0, resp_valid}, 32'd1);
        chk("R4 set", {24'd0, resp_set}, {24'd0, a[12:5]});
        chk(cfg_sel ? "R3 bank" : "R2 bank", {31'd0, resp_bank}, {31'd0, cfg_sel ? a[23] : a[14]});
        chk(rq, {31'd0, resp_hit}, {31'd0, exp_hit});
        if (exp_hit) chk(rq, {31'd0, resp_way}, {31'd0, exp_way});
    endtask

    task automatic do_fill(input logic [31:0] a);
        @(negedge clk);
        fill = 1'b1; fill_addr = a;
        @(negedge clk);
        fill = 1'b0;
    endtask

    // Change mode with an optional lookup and fill in the same cycle.
    task automatic flip(input bit m, input bit with_req, input logic [31:0] a,
                        input bit with_fill, input logic [31:0] fa);
        @(negedge clk);
        cfg_sel = m; req = with_req; addr = a; fill = with_fill; fill_addr = fa;
        @(negedge clk);
        req = 1'b0; fill = 1'b0;
        if (with_req) chk("R9 flip-cycle miss", {31'd0, resp_hit}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 resp_valid after reset", {31'd0, resp_valid}, 32'd0);
        chk("R1 resp_hit after reset", {31'd0, resp_hit}, 32'd0);
        look(32'h0000_1000, "R1 empty miss", 1'b0, 1'b0);
        look(32'h0000_0000, "R1 empty miss", 1'b0, 1'b0);
    endtask

    task automatic t_decode();
        look(32'h0000_0000, "R2 page0", 1'b0, 1'b0);
        look(32'h0000_4000, "R2 page1", 1'b0, 1'b0);
        look(32'h0000_8000, "R2 page2", 1'b0, 1'b0);
        look(32'h0080_0000, "R2 bit23 ignored for bank", 1'b0, 1'b0);
        look(32'h0000_1FE0, "R4 top set", 1'b0, 1'b0);
        @(negedge clk);
        chk("R4 single-cycle valid", {31'd0, resp_valid}, 32'd0);
    endtask

    task automatic t_fill_hit();
        do_fill(32'h0001_2340);
        look(32'h0001_2340, "R7 first fill way0", 1'b1, 1'b0);
        look(32'h0001_235C, "R6 same line hit", 1'b1, 1'b0);
        look(32'h0081_2340, "R5 bit23 in tag", 1'b0, 1'b0);
        look(32'h0001_6340, "R6 other bank miss", 1'b0, 1'b0);
    endtask

    task automatic t_lru();
        do_fill(32'h0002_0100);
        do_fill(32'h0004_0100);
        look(32'h0004_0100, "R7 second fill way1", 1'b1, 1'b1);
        look(32'h0002_0100, "R8 hit way0", 1'b1, 1'b0);
        do_fill(32'h0008_0100);
        look(32'h0004_0100, "R8 lru victim evicted", 1'b0, 1'b0);
        look(32'h0002_0100, "R8 mru kept", 1'b1, 1'b0);
        look(32'h0008_0100, "R8 new in way1", 1'b1, 1'b1);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        fill = 1'b1; fill_addr = 32'h0010_0200; req = 1'b1; addr = 32'h0010_0200;
        @(negedge clk);
        fill = 1'b0; req = 1'b0;
        chk("R10 lookup sees pre-fill", {31'd0, resp_hit}, 32'd0);
        look(32'h0010_0200, "R10 hit after fill", 1'b1, 1'b0);
    endtask

    task automatic t_flip();
        flip(1'b1, 1'b1, 32'h0002_0100, 1'b0, 32'h0);
        look(32'h0002_0100, "R9 flushed entry misses", 1'b0, 1'b0);
        look(32'h0080_0000, "R3 bit23 bank B", 1'b0, 1'b0);
        look(32'h0000_4000, "R3 bit14 bank A", 1'b0, 1'b0);
        do_fill(32'h0000_0400);
        look(32'h0000_0400, "R3 hit in mode1", 1'b1, 1'b0);
        look(32'h0000_4400, "R5 bit14 in tag", 1'b0, 1'b0);
        flip(1'b0, 1'b0, 32'h0, 1'b1, 32'h0020_0040);
        look(32'h0020_0040, "R9 fill dropped on flip", 1'b0, 1'b0);
        look(32'h0000_0400, "R9 old mode entry gone", 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_fill_hit();
        t_lru();
        t_same_cycle();
        t_flip();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule